// File: doc/BRIEF.md
# Prioritised Memory Protection Permission Checker

This block decides whether one memory access may proceed under a set of protection entries. Each entry provides an inclusive byte range (low and high bound, already decoded) and a configuration byte that holds read, write and execute grants, a matching mode and a lock flag. The access is described by its start address, its size in bytes, the permissions it needs and whether it comes from machine mode. Two global policy bits are also inputs: a lockdown bit that switches to a table-driven permission rule, and a deny-by-default bit that closes the fallback path.

Entries are scanned from index 0 upward. The first active entry that the access touches decides the outcome. If no active entry is touched, or the active-rule count is zero, a fallback policy decides. The decision is evaluated combinationally, and a pass/fail flag, the granted permission set and a done strobe are registered one cycle after a valid request.

Top module: `pmp_perm_check`

## Requirements
- R1: Entries are examined from index 0 upward. The lowest-indexed active entry that contains the first or the last byte of the access decides, even when a higher entry would give a different result.
- R2: When exactly one of the access's first and last bytes lies inside the deciding entry's range, the access is denied and the granted set is 000.
- R3: When the deciding entry contains the whole access, the access passes only if every requested bit is in the granted set. Permission vectors use bit 0 = read, bit 1 = write, bit 2 = execute.
- R4: With lockdown clear, a machine-mode access to an entry whose lock bit (config bit 7) is clear is granted 111. In every other case the granted set is config bits [2:0] (read, write, execute).
- R5: With lockdown set, machine mode indexes a table with {lock, read, write, execute}. Indices 0, 1, 4, 5, 6, 7 and 8 grant nothing. Indices 2, 3 and 14 grant read+write. Indices 9 and 10 grant execute. Indices 11 and 13 grant read+execute. Indices 12 and 15 grant read.
- R6: With lockdown set, non-machine modes use the same index. Indices 0, 8, 9, 12, 13 and 14 grant nothing. Indices 1, 10 and 11 grant execute. Indices 2, 4 and 15 grant read. Indices 3 and 6 grant read+write. Index 5 grants read+execute. Index 7 grants all three.
- R7: On the fallback path with deny-by-default set, every access fails with granted set 000, machine mode included.
- R8: On the fallback path with lockdown set and deny-by-default clear, a machine-mode access that does not request execute passes with granted set 011. Any other access fails with 000.
- R9: On the fallback path with both policy bits clear, machine mode passes with 111 and other modes fail with 000.
- R10: The last byte of the access is the address plus the size minus one. A size of 0 means a 4-byte word.
- R11: done_o pulses high for exactly the cycle after each cycle with req_valid_i high. allow_o and perm_ok_o take the new result on that edge and hold their values while no request arrives. All outputs reset to 0.
- R12: An active-rule count of 0 forces the fallback path, whatever the entries hold.
- R13: An entry whose mode field (config bits [4:3]) is 00 is off: it never matches, and it never causes a partial-overlap denial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| addr_i | input | AW | Access start byte address |
| size_i | input | SIZE_W | Access size in bytes, 0 = one word |
| perm_req_i | input | 3 | Requested permissions {X,W,R} |
| mach_mode_i | input | 1 | Access comes from machine mode |
| ent_lo_i | input | N_ENTRY*AW | Packed inclusive low bounds, entry 0 in the lowest slice |
| ent_hi_i | input | N_ENTRY*AW | Packed inclusive high bounds |
| ent_cfg_i | input | N_ENTRY*8 | Packed configuration bytes |
| rule_cnt_i | input | CNT_W | Number of active rules |
| lockdown_i | input | 1 | Table-driven permission rule enable |
| deny_default_i | input | 1 | Fallback path denies everything |
| done_o | output | 1 | Result strobe |
| allow_o | output | 1 | Access passes |
| perm_ok_o | output | 3 | Granted permission set {X,W,R} |

## Verification
Every result is due on the first rising edge after the cycle in which req_valid_i is high. No other register sits on the path. The bench drives a request on a falling edge and samples done_o, allow_o and perm_ok_o on the next falling edge, half a period after the capturing edge. To check holding, the bench changes the inputs with the strobe low and samples again one falling edge later, where done_o must be low and the other two outputs unchanged.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;
  localparam int CFG_W   = 8;
  localparam int BIT_R   = 0;
  localparam int BIT_W   = 1;
  localparam int BIT_X   = 2;
  localparam int BIT_L   = 7;
  localparam int MODE_LO = 3;

  typedef logic [2:0] perm_t;  // {X,W,R}

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b001;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_X    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  // idx = {L,R,W,X}
  function automatic perm_t lock_tbl_mach(input logic [3:0] idx);
    case (idx)
      4'd2, 4'd3, 4'd14: return P_RW;
      4'd9, 4'd10:       return P_X;
      4'd11, 4'd13:      return P_RX;
      4'd12, 4'd15:      return P_R;
      default:           return P_NONE;
    endcase
  endfunction

  function automatic perm_t lock_tbl_user(input logic [3:0] idx);
    case (idx)
      4'd1, 4'd10, 4'd11: return P_X;
      4'd2, 4'd4, 4'd15:  return P_R;
      4'd3, 4'd6:         return P_RW;
      4'd5:               return P_RX;
      4'd7:               return P_RWX;
      default:            return P_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_chk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    acc_lo_i,
  input  logic [AW-1:0]    acc_hi_i,
  input  logic [AW-1:0]    lo_i,
  input  logic [AW-1:0]    hi_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             mach_i,
  input  logic             lockdown_i,
  output logic             touch_o,
  output logic             part_o,
  output perm_t            set_o
);
  logic       first_in, last_in, active;
  logic [3:0] tbl_idx;
  perm_t      normal_set, table_set;

  assign active   = cfg_i[MODE_LO+1:MODE_LO] != 2'b00;
  assign first_in = (acc_lo_i >= lo_i) && (acc_lo_i <= hi_i);
  assign last_in  = (acc_hi_i >= lo_i) && (acc_hi_i <= hi_i);
  assign touch_o  = active && (first_in || last_in);
  assign part_o   = active && (first_in ^ last_in);

  assign tbl_idx    = {cfg_i[BIT_L], cfg_i[BIT_R], cfg_i[BIT_W], cfg_i[BIT_X]};
  assign table_set  = mach_i ? lock_tbl_mach(tbl_idx) : lock_tbl_user(tbl_idx);
  assign normal_set = (mach_i && !cfg_i[BIT_L]) ? P_RWX : cfg_i[2:0];

  always_comb begin
    if (part_o)          set_o = P_NONE;
    else if (lockdown_i) set_o = table_set;
    else                 set_o = normal_set;
  end

  // R13: an inactive entry never claims the access
  always_comb begin
    if (!active) a_r13_off_silent: assert (!touch_o && !part_o);
  end
endmodule

// File: rtl/pmp_default_policy.sv
module pmp_default_policy
  import pmp_chk_pkg::*;
(
  input  logic  mach_i,
  input  perm_t perm_req_i,
  input  logic  lockdown_i,
  input  logic  deny_default_i,
  output logic  ok_o,
  output perm_t set_o
);
  always_comb begin
    if (deny_default_i) begin
      ok_o  = 1'b0;
      set_o = P_NONE;
    end else if (lockdown_i) begin
      ok_o  = mach_i && !perm_req_i[BIT_X];
      set_o = ok_o ? P_RW : P_NONE;
    end else begin
      ok_o  = mach_i;
      set_o = mach_i ? P_RWX : P_NONE;
    end
  end
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
  import pmp_chk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SIZE_W     = 4,
  parameter int N_ENTRY    = 4,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W     = $clog2(N_ENTRY + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [SIZE_W-1:0]        size_i,
  input  logic [2:0]               perm_req_i,
  input  logic                     mach_mode_i,
  input  logic [N_ENTRY*AW-1:0]    ent_lo_i,
  input  logic [N_ENTRY*AW-1:0]    ent_hi_i,
  input  logic [N_ENTRY*CFG_W-1:0] ent_cfg_i,
  input  logic [CNT_W-1:0]         rule_cnt_i,
  input  logic                     lockdown_i,
  input  logic                     deny_default_i,
  output logic                     done_o,
  output logic                     allow_o,
  output logic [2:0]               perm_ok_o
);
  logic [AW-1:0] eff_size, acc_hi;
  logic [N_ENTRY-1:0] touch, part;
  perm_t set_e [N_ENTRY];

  assign eff_size = (size_i == '0) ? AW'(WORD_BYTES) : AW'(size_i);
  assign acc_hi   = addr_i + eff_size - AW'(1);

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    pmp_entry_match #(.AW(AW)) u_match (
      .acc_lo_i   (addr_i),
      .acc_hi_i   (acc_hi),
      .lo_i       (ent_lo_i[g*AW +: AW]),
      .hi_i       (ent_hi_i[g*AW +: AW]),
      .cfg_i      (ent_cfg_i[g*CFG_W +: CFG_W]),
      .mach_i     (mach_mode_i),
      .lockdown_i (lockdown_i),
      .touch_o    (touch[g]),
      .part_o     (part[g]),
      .set_o      (set_e[g])
    );
  end

  logic  hit, hit_part;
  perm_t hit_set;

  // scan high to low so the lowest index is the last to win
  always_comb begin
    hit      = 1'b0;
    hit_part = 1'b0;
    hit_set  = P_NONE;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (touch[i]) begin
        hit      = 1'b1;
        hit_part = part[i];
        hit_set  = set_e[i];
      end
    end
  end

  logic  dflt_ok;
  perm_t dflt_set;

  pmp_default_policy u_dflt (
    .mach_i         (mach_mode_i),
    .perm_req_i     (perm_req_i),
    .lockdown_i     (lockdown_i),
    .deny_default_i (deny_default_i),
    .ok_o           (dflt_ok),
    .set_o          (dflt_set)
  );

  logic  use_dflt, allow_d;
  perm_t set_d;

  assign use_dflt = (rule_cnt_i == '0) || !hit;
  assign set_d    = use_dflt ? dflt_set : hit_set;
  assign allow_d  = use_dflt ? dflt_ok
                             : (!hit_part && ((perm_req_i & ~hit_set) == 3'b000));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      allow_o   <= 1'b0;
      perm_ok_o <= 3'b000;
    end else begin
      done_o <= req_valid_i;
      if (req_valid_i) begin
        allow_o   <= allow_d;
        perm_ok_o <= set_d;
      end
    end
  end

  a_r11_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(allow_o) && $stable(perm_ok_o)));
  a_r3_allow_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!allow_o || (($past(perm_req_i) & ~perm_ok_o) == 3'b000)));
  a_r7_mmwp_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && deny_default_i && rule_cnt_i == '0) |=> (!allow_o && perm_ok_o == 3'b000));
  a_r8_no_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && lockdown_i && rule_cnt_i == '0 && perm_req_i[2]) |=> !allow_o);
endmodule

// File: tb/tb_pmp_perm_check.sv
module tb_pmp_perm_check;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int NE = 4;
  localparam int CW = $clog2(NE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid;
  logic [AW-1:0]     addr;
  logic [SW-1:0]     size;
  logic [2:0]        perm_req;
  logic              mach;
  logic [NE*AW-1:0]  ent_lo, ent_hi;
  logic [NE*8-1:0]   ent_cfg;
  logic [CW-1:0]     rule_cnt;
  logic              mml, mmwp;
  logic              done, allow;
  logic [2:0]        perm_ok;

  pmp_perm_check #(.AW(AW), .SIZE_W(SW), .N_ENTRY(NE), .WORD_BYTES(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .addr_i(addr),
    .size_i(size), .perm_req_i(perm_req), .mach_mode_i(mach),
    .ent_lo_i(ent_lo), .ent_hi_i(ent_hi), .ent_cfg_i(ent_cfg),
    .rule_cnt_i(rule_cnt), .lockdown_i(mml), .deny_default_i(mmwp),
    .done_o(done), .allow_o(allow), .perm_ok_o(perm_ok)
  );

  typedef struct packed {
    logic [3:0]  rid;
    logic [31:0] addr;
    logic [3:0]  size;
    logic [2:0]  perm;
    logic        mach, mml, mmwp;
    logic [7:0]  cfg0;
    logic [2:0]  rcnt;
    logic        allow;
    logic [2:0]  aset;
  } vec_t;

  // fixed entries: e0 [100,1FF] cfg from vector, e1 [100,3FF] RW,
  // e2 [1000,1FFF] mode off, e3 [2000,2FFF] locked X
  localparam int N_VEC = 26;
  localparam vec_t VEC [N_VEC] = '{
    '{4'd3,  32'h120,  4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 8'h09, 3'd3, 1'b1, 3'b001}, // R3
    '{4'd3,  32'h120,  4'd4, 3'b010, 1'b0, 1'b0, 1'b0, 8'h09, 3'd3, 1'b0, 3'b001}, // R3
    '{4'd4,  32'h120,  4'd4, 3'b010, 1'b1, 1'b0, 1'b0, 8'h09, 3'd3, 1'b1, 3'b111}, // R4
    '{4'd4,  32'h120,  4'd4, 3'b010, 1'b1, 1'b0, 1'b0, 8'h89, 3'd3, 1'b0, 3'b001}, // R4
    '{4'd1,  32'h300,  4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 8'h09, 3'd3, 1'b1, 3'b011}, // R1
    '{4'd1,  32'h150,  4'd4, 3'b010, 1'b0, 1'b0, 1'b0, 8'h09, 3'd3, 1'b0, 3'b001}, // R1
    '{4'd2,  32'h1FE,  4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 8'h0F, 3'd3, 1'b0, 3'b000}, // R2
    '{4'd10, 32'h1FC,  4'd0, 3'b001, 1'b0, 1'b0, 1'b0, 8'h09, 3'd3, 1'b1, 3'b001}, // R10
    '{4'd10, 32'h1FD,  4'd3, 3'b001, 1'b0, 1'b0, 1'b0, 8'h09, 3'd3, 1'b1, 3'b001}, // R10
    '{4'd10, 32'h1FD,  4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 8'h09, 3'd3, 1'b0, 3'b000}, // R10
    '{4'd13, 32'h1800, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 8'h09, 3'd3, 1'b0, 3'b000}, // R13
    '{4'd9,  32'h1800, 4'd4, 3'b100, 1'b1, 1'b0, 1'b0, 8'h09, 3'd3, 1'b1, 3'b111}, // R9
    '{4'd7,  32'h1800, 4'd4, 3'b001, 1'b1, 1'b0, 1'b1, 8'h09, 3'd3, 1'b0, 3'b000}, // R7
    '{4'd8,  32'h1800, 4'd4, 3'b001, 1'b1, 1'b1, 1'b0, 8'h09, 3'd3, 1'b1, 3'b011}, // R8
    '{4'd8,  32'h1800, 4'd4, 3'b100, 1'b1, 1'b1, 1'b0, 8'h09, 3'd3, 1'b0, 3'b000}, // R8
    '{4'd8,  32'h1800, 4'd4, 3'b001, 1'b0, 1'b1, 1'b0, 8'h09, 3'd3, 1'b0, 3'b000}, // R8
    '{4'd12, 32'h120,  4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 8'h09, 3'd0, 1'b0, 3'b000}, // R12
    '{4'd12, 32'h120,  4'd4, 3'b001, 1'b1, 1'b0, 1'b0, 8'h09, 3'd0, 1'b1, 3'b111}, // R12
    '{4'd5,  32'h120,  4'd4, 3'b001, 1'b1, 1'b1, 1'b0, 8'h8F, 3'd3, 1'b1, 3'b001}, // R5
    '{4'd5,  32'h120,  4'd4, 3'b001, 1'b1, 1'b1, 1'b0, 8'h0B, 3'd3, 1'b0, 3'b000}, // R5
    '{4'd5,  32'h120,  4'd4, 3'b100, 1'b1, 1'b1, 1'b0, 8'h8D, 3'd3, 1'b1, 3'b101}, // R5
    '{4'd6,  32'h120,  4'd4, 3'b010, 1'b0, 1'b1, 1'b0, 8'h0F, 3'd3, 1'b1, 3'b111}, // R6
    '{4'd6,  32'h120,  4'd4, 3'b100, 1'b0, 1'b1, 1'b0, 8'h8C, 3'd3, 1'b0, 3'b000}, // R6
    '{4'd6,  32'h120,  4'd4, 3'b100, 1'b0, 1'b1, 1'b0, 8'h0C, 3'd3, 1'b1, 3'b100}, // R6
    '{4'd4,  32'h2000, 4'd4, 3'b100, 1'b1, 1'b0, 1'b0, 8'h09, 3'd3, 1'b1, 3'b100}, // R4
    '{4'd4,  32'h2010, 4'd4, 3'b001, 1'b1, 1'b0, 1'b0, 8'h09, 3'd3, 1'b0, 3'b100}  // R4
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    addr     = v.addr;
    size     = v.size;
    perm_req = v.perm;
    mach     = v.mach;
    mml      = v.mml;
    mmwp     = v.mmwp;
    ent_cfg[7:0] = v.cfg0;
    rule_cnt = v.rcnt;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    req_valid = 1'b0;
    ent_lo  = {32'h2000, 32'h1000, 32'h100, 32'h100};
    ent_hi  = {32'h2FFF, 32'h1FFF, 32'h3FF, 32'h1FF};
    ent_cfg = {8'h8C, 8'h07, 8'h0B, 8'h09};
    apply(VEC[0]);
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11 reset done", {3'b0, done}, 4'd0);
    check("R11 reset allow/set", {allow, perm_ok}, 4'd0);
    rst_n = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R%0d vec%0d allow", VEC[i].rid, i), {3'b0, allow}, {3'b0, VEC[i].allow});
      check($sformatf("R%0d vec%0d set", VEC[i].rid, i), {1'b0, perm_ok}, {1'b0, VEC[i].aset});
      check($sformatf("R11 vec%0d done", i), {3'b0, done}, 4'd1);
    end

    // R11 hold: last vector left allow=0, set=100; change inputs without strobe
    apply(VEC[2]);
    @(negedge clk);
    check("R11 done low without request", {3'b0, done}, 4'd0);
    check("R11 outputs held", {allow, perm_ok}, 4'b0100);
    // R11 new request after idle updates outputs
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 update after idle", {allow, perm_ok}, 4'b1111);
    @(negedge clk);
    check("R11 single-cycle done", {3'b0, done}, 4'd0);

    // R11 back-to-back requests
    apply(VEC[12]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R7 back-to-back first", {allow, perm_ok}, 4'b0000);
    apply(VEC[11]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 back-to-back second", {allow, perm_ok}, 4'b1111);
    check("R11 done stays high", {3'b0, done}, 4'd1);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule